// File: doc/BRIEF.md
# Predictive PWM On-Time Calculator

This block works out, ahead of the next switching pulse, how long the power switch must stay on so that the inductor current rises from a sampled starting level to a requested level. It does not compare the current against a threshold during the pulse. It uses inductor physics instead: the on-time is a cached scale factor (inductance over the voltage across the inductor, held in Q8.8 fixed point) multiplied by twice the current step. Firmware refreshes the scale factor only when the supply voltage moves, so the same factor serves many switching periods. The start current comes from a converter sample taken at a fixed point of the previous period.

A second mode serves voltage feed-forward. In that mode the duty count is the output voltage times the switching period, divided by the input voltage. A bit-serial restoring divider computes it over several cycles and raises a busy flag while it runs. Both modes saturate at a programmable maximum on-time count. Each mode reports its result with a single-cycle done strobe, so the PWM timer can load the value before its next pulse.

Top module: `ontime_predictor`

## Requirements
- R1: With mode_i=0, the result is (k_lv_i*2*(i_target_i-i_start_i)+128)>>8. k_lv_i is unsigned Q8.8 with 8 fraction bits, so this is the product rounded half-up to whole counts.
- R2: With mode_i=0, when i_target_i is less than or equal to i_start_i, the result is 0.
- R3: Every result saturates at the max_on_i value sampled with the accepted start strobe.
- R4: With mode_i=0, done_o is high for exactly the one cycle after the clock edge that accepts start_i. on_time_o changes only when done_o is high and holds its value at all other times.
- R5: With mode_i=1 and v_in_i nonzero, the result is floor(v_out_i*period_i/v_in_i), clamped as in R3.
- R6: With mode_i=1 and v_in_i nonzero, busy_o rises after the accepting edge and stays high for V_W+T_W+1 cycles (29 with the default parameters). done_o is never high while busy_o is high, and done_o rises in the cycle that busy_o falls.
- R7: With mode_i=1 and v_in_i equal to 0, the result is max_on_i. It is reported with done_o in the cycle after the accepting edge, and busy_o stays low.
- R8: A start_i that arrives while busy_o is high is ignored. It produces no done_o and does not change the result or the latched limit.
- R9: After reset, busy_o, done_o and on_time_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted when not busy |
| mode_i | input | 1 | 0: current step, 1: feed-forward divide |
| i_target_i | input | I_W | Requested inductor current |
| i_start_i | input | I_W | Sampled starting inductor current |
| k_lv_i | input | K_W | L/V scale factor, unsigned Q8.8 |
| v_out_i | input | V_W | Output voltage for feed-forward |
| v_in_i | input | V_W | Input voltage for feed-forward |
| period_i | input | T_W | Switching period in counts |
| max_on_i | input | T_W | Saturation limit for the on-time |
| busy_o | output | 1 | Divider running |
| done_o | output | 1 | Result valid strobe, one cycle |
| on_time_o | output | T_W | On-time or duty count |

## Verification
The checker module tests on every cycle the behaviours that relate the ports to each other. These are the one-cycle done in current mode, a zero result for a non-positive current step, the limit never being exceeded, the result holding between done strobes, done never overlapping busy and appearing as busy falls, the zero-divisor shortcut, and the latched limit staying fixed while busy. Only the bench scenarios can show the exact arithmetic: rounding of the Q8.8 product, floor division of the feed-forward quotient, and the exact divider latency. The scenarios also show that a strobe during a division leaves the final quotient intact.

// File: rtl/ontime_pkg.sv
package ontime_pkg;
  localparam int unsigned FRAC = 8;  // Q8.8 fraction bits of the L/V factor

  typedef enum logic {
    MODE_CURRENT = 1'b0,
    MODE_FEEDFWD = 1'b1
  } calc_mode_e;
endpackage

// File: rtl/ontime_slope.sv
module ontime_slope
  import ontime_pkg::*;
#(
  parameter int unsigned I_W = 12,
  parameter int unsigned K_W = 16,
  localparam int unsigned P_W = K_W + I_W,
  localparam int unsigned O_W = P_W + 2 - FRAC
) (
  input  logic [I_W-1:0] target_i,
  input  logic [I_W-1:0] start_i,
  input  logic [K_W-1:0] k_i,
  output logic [O_W-1:0] val_o
);
  localparam logic [P_W+1:0] HALF = (P_W+2)'(1) << (FRAC - 1);

  logic [I_W:0]   diff;
  logic           non_pos;
  logic [P_W-1:0] prod;
  logic [P_W+1:0] rnd;

  always_comb begin
    diff    = {1'b0, target_i} - {1'b0, start_i};
    non_pos = diff[I_W] || (diff == '0);
    prod    = {{I_W{1'b0}}, k_i} * {{K_W{1'b0}}, diff[I_W-1:0]};
    rnd     = {1'b0, prod, 1'b0} + HALF;  // x2 then round half-up
    val_o   = non_pos ? '0 : rnd[P_W+1:FRAC];
  end
endmodule

// File: rtl/ontime_div.sv
module ontime_div #(
  parameter int unsigned NW  = 28,
  parameter int unsigned DVW = 12,
  localparam int unsigned CW = $clog2(NW + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [NW-1:0]  num_i,
  input  logic [DVW-1:0] den_i,
  output logic           fin_o,
  output logic [NW-1:0]  quo_o
);
  logic [DVW-1:0] rem_q, den_q;
  logic [NW-1:0]  quo_q;
  logic [CW-1:0]  cnt_q;
  logic           run_q, fin_q;

  logic [DVW:0]   rem_sh;
  logic           take;
  logic [DVW:0]   rem_sub;

  always_comb begin
    rem_sh  = {rem_q, quo_q[NW-1]};
    take    = rem_sh >= {1'b0, den_q};
    rem_sub = rem_sh - {1'b0, den_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      den_q <= '0;
      quo_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (load_i) begin
        rem_q <= '0;
        den_q <= den_i;
        quo_q <= num_i;
        cnt_q <= CW'(NW);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= take ? rem_sub[DVW-1:0] : rem_sh[DVW-1:0];
        quo_q <= {quo_q[NW-2:0], take};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0;
          fin_q <= 1'b1;
        end
      end
    end
  end

  assign fin_o = fin_q;
  assign quo_o = quo_q;
endmodule

// File: rtl/ontime_clamp.sv
module ontime_clamp #(
  parameter int unsigned IN_W  = 28,
  parameter int unsigned OUT_W = 16
) (
  input  logic [IN_W-1:0]  val_i,
  input  logic [OUT_W-1:0] lim_i,
  output logic [OUT_W-1:0] out_o
);
  always_comb begin
    out_o = (val_i > IN_W'(lim_i)) ? lim_i : val_i[OUT_W-1:0];
  end
endmodule

// File: rtl/ontime_predictor.sv
module ontime_predictor
  import ontime_pkg::*;
#(
  parameter int unsigned I_W = 12,
  parameter int unsigned K_W = 16,
  parameter int unsigned V_W = 12,
  parameter int unsigned T_W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           mode_i,
  input  logic [I_W-1:0] i_target_i,
  input  logic [I_W-1:0] i_start_i,
  input  logic [K_W-1:0] k_lv_i,
  input  logic [V_W-1:0] v_out_i,
  input  logic [V_W-1:0] v_in_i,
  input  logic [T_W-1:0] period_i,
  input  logic [T_W-1:0] max_on_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [T_W-1:0] on_time_o
);
  localparam int unsigned PW = K_W + I_W + 2 - FRAC;
  localparam int unsigned QW = V_W + T_W;
  localparam int unsigned MW = (PW > QW) ? PW : QW;

  logic           busy_q, done_q;
  logic [T_W-1:0] on_time_q, max_q;
  logic           accept, ff_sel, div_load, div_fin;
  logic [PW-1:0]  slope_val;
  logic [QW-1:0]  quot, num;
  logic [MW-1:0]  clamp_in;
  logic [T_W-1:0] clamp_lim, clamp_out;

  assign accept   = start_i && !busy_q;
  assign ff_sel   = (calc_mode_e'(mode_i) == MODE_FEEDFWD);
  assign div_load = accept && ff_sel && (v_in_i != '0);
  assign num      = {{T_W{1'b0}}, v_out_i} * {{V_W{1'b0}}, period_i};

  ontime_slope #(.I_W(I_W), .K_W(K_W)) u_slope (
    .target_i(i_target_i),
    .start_i (i_start_i),
    .k_i     (k_lv_i),
    .val_o   (slope_val)
  );

  ontime_div #(.NW(QW), .DVW(V_W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(div_load),
    .num_i (num),
    .den_i (v_in_i),
    .fin_o (div_fin),
    .quo_o (quot)
  );

  // a divide in flight owns the clamp; otherwise the current path uses it
  assign clamp_in  = busy_q ? MW'(quot) : MW'(slope_val);
  assign clamp_lim = busy_q ? max_q : max_on_i;

  ontime_clamp #(.IN_W(MW), .OUT_W(T_W)) u_clamp (
    .val_i(clamp_in),
    .lim_i(clamp_lim),
    .out_o(clamp_out)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      on_time_q <= '0;
      max_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        max_q <= max_on_i;
        if (!ff_sel) begin
          on_time_q <= clamp_out;
          done_q    <= 1'b1;
        end else if (v_in_i == '0) begin
          on_time_q <= max_on_i;
          done_q    <= 1'b1;
        end else begin
          busy_q <= 1'b1;
        end
      end else if (busy_q && div_fin) begin
        on_time_q <= clamp_out;
        done_q    <= 1'b1;
        busy_q    <= 1'b0;
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign on_time_o = on_time_q;
endmodule

// File: rtl/ontime_predictor_chk.sv
module ontime_predictor_chk #(
  parameter int unsigned I_W = 12,
  parameter int unsigned V_W = 12,
  parameter int unsigned T_W = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           mode_i,
  input logic [I_W-1:0] i_target_i,
  input logic [I_W-1:0] i_start_i,
  input logic [V_W-1:0] v_in_i,
  input logic [T_W-1:0] max_on_i,
  input logic           busy_o,
  input logic           done_o,
  input logic [T_W-1:0] on_time_o,
  input logic [T_W-1:0] max_q
);
  a_r2_nonpos_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && !mode_i && (i_target_i <= i_start_i) |=> done_o && (on_time_o == '0));

  a_r3_within_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> on_time_o <= max_q);

  a_r4_done_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && !mode_i |=> done_o && !busy_o);

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(on_time_o));

  a_r6_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);

  a_r6_fall_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r6_busy_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && mode_i && (v_in_i != '0) |=> busy_o);

  a_r7_zero_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && mode_i && (v_in_i == '0) |=> done_o && !busy_o && (on_time_o == $past(max_on_i)));

  a_r8_limit_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(max_q));
endmodule

bind ontime_predictor ontime_predictor_chk #(.I_W(I_W), .V_W(V_W), .T_W(T_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .mode_i    (mode_i),
  .i_target_i(i_target_i),
  .i_start_i (i_start_i),
  .v_in_i    (v_in_i),
  .max_on_i  (max_on_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .on_time_o (on_time_o),
  .max_q     (max_q)
);

// File: tb/ontime_predictor_tb.sv
`timescale 1ns/1ps
module ontime_predictor_tb;
  localparam int unsigned I_W = 12, K_W = 16, V_W = 12, T_W = 16;
  localparam int DIV_CYC = V_W + T_W + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, mode = 1'b0;
  logic [I_W-1:0] tgt = '0, ist = '0;
  logic [K_W-1:0] k = '0;
  logic [V_W-1:0] vout = '0, vin = '0;
  logic [T_W-1:0] per = '0, mx = '0;
  logic busy, done;
  logic [T_W-1:0] ot;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ontime_predictor #(.I_W(I_W), .K_W(K_W), .V_W(V_W), .T_W(T_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .i_target_i(tgt), .i_start_i(ist), .k_lv_i(k), .v_out_i(vout),
    .v_in_i(vin), .period_i(per), .max_on_i(mx),
    .busy_o(busy), .done_o(done), .on_time_o(ot)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint exp_cur(longint t, longint s, longint kk, longint m);
    longint d = t - s;
    longint r;
    if (d <= 0) return 0;
    r = (kk * 2 * d + 128) >> 8;
    return (r > m) ? m : r;
  endfunction

  function automatic longint exp_ff(longint vo, longint p, longint vi, longint m);
    longint r;
    if (vi == 0) return m;
    r = (vo * p) / vi;
    return (r > m) ? m : r;
  endfunction

  task automatic t_reset();
    check(busy == 1'b0, "R9 busy", busy, 0);
    check(done == 1'b0, "R9 done", done, 0);
    check(ot == '0, "R9 on_time", ot, 0);
  endtask

  task automatic t_current(input int t, input int s, input int kk, input int m, input string tag);
    longint e = exp_cur(t, s, kk, m);
    @(negedge clk);
    mode = 1'b0; tgt = I_W'(t); ist = I_W'(s); k = K_W'(kk); mx = T_W'(m); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1, {tag, " R4 done"}, done, 1);
    check(ot == T_W'(e), tag, ot, e);
    tgt = '0; ist = '0;
    @(negedge clk);
    check(done == 1'b0 && ot == T_W'(e), {tag, " R4 hold"}, ot, e);
  endtask

  task automatic t_ff(input int vo, input int p, input int vi, input int m,
                      input bit poke, input string tag);
    longint e = exp_ff(vo, p, vi, m);
    int waited = 0;
    @(negedge clk);
    mode = 1'b1; vout = V_W'(vo); per = T_W'(p); vin = V_W'(vi); mx = T_W'(m); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (vi == 0) begin
      check(done == 1'b1 && busy == 1'b0, "R7 immediate", done, 1);
      check(ot == T_W'(e), "R7 max", ot, e);
      return;
    end
    check(busy == 1'b1, "R6 busy rise", busy, 1);
    while (!done && waited < 100) begin
      if (poke && waited == 3) begin
        mode = 1'b0; tgt = 12'd50; ist = 12'd0; k = 16'h0100; mx = 16'd7; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      waited++;
      if (poke && waited == 4)
        check(done == 1'b0 && busy == 1'b1, "R8 no done on busy start", done, 0);
    end
    start = 1'b0;
    check(waited == DIV_CYC, "R6 latency", waited, DIV_CYC);
    check(busy == 1'b0, "R6 busy fell", busy, 0);
    check(ot == T_W'(e), tag, ot, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_current(100, 40, 16'h0180, 60000, "R1 exact");
    t_current(23, 20, 16'h0155, 60000, "R1 round");
    t_current(10, 20, 16'h0180, 60000, "R2 negative");
    t_current(77, 77, 16'h0180, 60000, "R2 equal");
    t_current(4095, 0, 16'hFFFF, 1000, "R3 clamp");
    t_current(4095, 0, 16'h0200, 0, "R3 zero limit");
    t_ff(1200, 1000, 2400, 60000, 1'b0, "R5 exact");
    t_ff(1000, 777, 3000, 60000, 1'b0, "R5 floor");
    t_ff(4000, 5000, 1, 60000, 1'b0, "R5 R3 clamp");
    t_ff(1000, 2000, 0, 4321, 1'b0, "R7 zero vin");
    t_ff(900, 1000, 300, 60000, 1'b1, "R8 result kept");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    finished = 1;
    $finish;
  end
endmodule